// File: doc/BRIEF.md
# Operand Addressing-Mode Fetch Unit

This unit obtains the operand for an accumulator-style processor once the instruction has been decoded. A caller presents a 3-bit addressing-mode code, a 16-bit operand field, and the present index and stack-pointer register values, then raises `start` for one cycle. The unit stores the request and works out the effective address. It issues zero, one or two reads to a single-port memory and then returns the operand on `result`, with a one-cycle `done` pulse.

Every memory read goes through an address register that drives `mem_addr`. The word that comes back is caught in a data register. For the pointer-chasing mode, that caught word becomes the address of the second read. The memory side uses a request/ready handshake. `mem_req` stays high with a steady address until the memory raises `mem_ready` together with the read data. Decode, arithmetic, flags and program-counter stepping are handled by other blocks.

Top module: `operand_fetch`

## Requirements
- R1: Mode code 0 (immediate) returns the operand field unchanged on `result`, makes no memory access and leaves `illegal` low.
- R2: Mode code 1 (direct) makes exactly one read at the operand field and returns the word read.
- R3: Mode code 2 (indirect) makes two reads. The first is at the operand field. The second is at the word that the first read returned, and the result is the word from the second read.
- R4: Mode code 3 (indexed) makes one read at index register plus operand field, with the sum wrapping modulo 2^16, and returns the word read.
- R5: Mode code 4 (stack) makes one read at stack pointer plus operand field, with the sum wrapping modulo 2^16, and returns the word read.
- R6: Mode codes 5, 6 and 7 set `illegal` high, return zero and make no memory access.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` does not change. Read data is taken in the cycle where `mem_ready` is high.
- R8: `done` is high for exactly one cycle per accepted request. `result` and `illegal` keep their values after `done` until the next accepted start.
- R9: While `busy` is high, `start` is ignored. The operation already running completes with its own inputs.
- R10: A synchronous active-high `rst` returns the unit to idle, even in the middle of an access. After reset, `busy`, `done` and `mem_req` are low and `mem_addr` and `result` are zero.
- R11: Mode, operand field, index and stack-pointer inputs are sampled only when a start is accepted. Changes to them during an operation do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a fetch; accepted only when idle |
| mode | input | 3 | Addressing-mode code (0 imm, 1 direct, 2 indirect, 3 indexed, 4 stack) |
| field | input | 16 | Operand field: value, address or offset |
| xreg | input | 16 | Index register value |
| sreg | input | 16 | Stack pointer value |
| busy | output | 1 | High from accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last request used an undefined mode code |
| result | output | 16 | Fetched operand, held until next accepted start |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory address register contents |
| mem_ready | input | 1 | Memory has returned the read data this cycle |
| mem_rdata | input | 16 | Memory read data, valid with mem_ready |

## Verification
Two situations are hard to reach from the ports: a second `start`, together with changed register inputs, arriving while a read is still outstanding, and a reset that lands in the middle of a wait state. The bench memory model has a separate response latency for each operation. Slow operations keep the unit in its wait states for several cycles, which gives the directed tests time to drive conflicting inputs or reset there. The model also records each read address and reports any change of `mem_addr` while a request is waiting.

// File: rtl/opf_pkg.sv
package opf_pkg;

    localparam int WORD_W = 16;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] AM_IMM = 3'd0;
    localparam logic [MODE_W-1:0] AM_DIR = 3'd1;
    localparam logic [MODE_W-1:0] AM_IND = 3'd2;
    localparam logic [MODE_W-1:0] AM_IDX = 3'd3;
    localparam logic [MODE_W-1:0] AM_STK = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR1 = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_ADDR2 = 3'd3,
        ST_WAIT2 = 3'd4,
        ST_DONE  = 3'd5
    } fstate_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [WORD_W-1:0] field;
        logic [WORD_W-1:0] xr;
        logic [WORD_W-1:0] sp;
    } fetch_req_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return (m <= AM_STK);
    endfunction

    function automatic logic mode_reads(input logic [MODE_W-1:0] m);
        return mode_legal(m) && (m != AM_IMM);
    endfunction

    function automatic logic mode_two_reads(input logic [MODE_W-1:0] m);
        return (m == AM_IND);
    endfunction

endpackage

// File: rtl/opf_addr_gen.sv
module opf_addr_gen
    import opf_pkg::*;
(
    input  fetch_req_t        req,
    output logic [WORD_W-1:0] addr
);
    // One shared adder: the base is picked by mode, the offset is always the field.
    logic [WORD_W-1:0] base;

    always_comb begin
        case (req.mode)
            AM_IDX:  base = req.xr;
            AM_STK:  base = req.sp;
            default: base = '0;
        endcase
        addr = base + req.field;   // wraps modulo 2^WORD_W
    end

endmodule

// File: rtl/opf_seq.sv
module opf_seq
    import opf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode_in,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              mem_ready,
    output fstate_e           state
);
    fstate_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (start) nxt = mode_reads(mode_in) ? ST_ADDR1 : ST_DONE;
            ST_ADDR1: nxt = ST_WAIT1;
            ST_WAIT1: if (mem_ready) nxt = mode_two_reads(mode_q) ? ST_ADDR2 : ST_DONE;
            ST_ADDR2: nxt = ST_WAIT2;
            ST_WAIT2: if (mem_ready) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R3
    second_read_only_indirect_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR2) |-> (mode_q == AM_IND));

    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/opf_mem_port.sv
module opf_mem_port
    import opf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_first,
    input  logic              load_chain,
    input  logic [WORD_W-1:0] first_addr,
    input  logic              capture,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] mar,
    output logic [WORD_W-1:0] mdr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mar <= '0;
            mdr <= '0;
        end else begin
            if (load_first)      mar <= first_addr;
            else if (load_chain) mar <= mdr;
            if (capture)         mdr <= rdata;
        end
    end

    // R3
    chain_addr_chk: assert property (@(posedge clk) disable iff (rst)
        load_chain |=> (mar == $past(mdr)));

endmodule

// File: rtl/operand_fetch.sv
module operand_fetch
    import opf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          mode,
    input  logic [15:0]         field,
    input  logic [15:0]         xreg,
    input  logic [15:0]         sreg,
    output logic                busy,
    output logic                done,
    output logic                illegal,
    output logic [15:0]         result,
    output logic                mem_req,
    output logic [15:0]         mem_addr,
    input  logic                mem_ready,
    input  logic [15:0]         mem_rdata
);
    fstate_e           state;
    fetch_req_t        req_q;
    logic              accept;
    logic              in_wait;
    logic              capture;
    logic              final_read;
    logic [WORD_W-1:0] first_addr;
    logic [WORD_W-1:0] mar;
    logic [WORD_W-1:0] mdr;
    logic [WORD_W-1:0] result_q;
    logic              illegal_q;

    assign accept     = start && (state == ST_IDLE);
    assign in_wait    = (state == ST_WAIT1) || (state == ST_WAIT2);
    assign capture    = in_wait && mem_ready;
    assign final_read = (state == ST_WAIT2) ||
                        ((state == ST_WAIT1) && !mode_two_reads(req_q.mode));

    // Request snapshot taken only on an accepted start.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.mode  <= mode;
            req_q.field <= field;
            req_q.xr    <= xreg;
            req_q.sp    <= sreg;
        end
    end

    opf_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_in   (mode),
        .mode_q    (req_q.mode),
        .mem_ready (mem_ready),
        .state     (state)
    );

    opf_addr_gen u_agen (
        .req  (req_q),
        .addr (first_addr)
    );

    opf_mem_port u_port (
        .clk        (clk),
        .rst        (rst),
        .load_first (state == ST_ADDR1),
        .load_chain (state == ST_ADDR2),
        .first_addr (first_addr),
        .capture    (capture),
        .rdata      (mem_rdata),
        .mar        (mar),
        .mdr        (mdr)
    );

    // Result and error flag: written at accept (no-memory modes) or on the last read.
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q  <= '0;
            illegal_q <= 1'b0;
        end else begin
            if (accept) begin
                illegal_q <= !mode_legal(mode);
                if (!mode_reads(mode))
                    result_q <= (mode == AM_IMM) ? field : '0;
            end else if (capture && final_read) begin
                result_q <= mem_rdata;
            end
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
    assign mem_req  = in_wait;
    assign mem_addr = mar;
    assign result   = result_q;
    assign illegal  = illegal_q;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R6
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && illegal) |-> (result == '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(result) && $stable(illegal)));

    // R9
    req_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(req_q));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!busy && !mem_req && mem_addr == '0 && result == '0));

    // R1
    no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

endmodule

// File: tb/operand_fetch_tb.sv
`timescale 1ns/1ps
module operand_fetch_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] field = '0, xreg = '0, sreg = '0;
    logic        busy, done, illegal, mem_req, mem_ready = 1'b0;
    logic [15:0] result, mem_addr, mem_rdata = '0;

    int checks = 0, failures = 0;
    int cur_lat = 0, wcnt = 0, n_acc = 0, hold_errs = 0;
    logic [15:0] acc_addr [2];
    logic [15:0] hold_addr = '0;

    always #4 clk = ~clk;

    operand_fetch u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .field(field),
        .xreg(xreg), .sreg(sreg), .busy(busy), .done(done), .illegal(illegal),
        .result(result), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    // Memory model: responds after cur_lat waiting cycles, data = memf(addr).
    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req && !mem_ready) begin
            if (wcnt > 0 && mem_addr != hold_addr) hold_errs++;
            if (wcnt == cur_lat) begin
                mem_ready = 1'b1;
                mem_rdata = memf(mem_addr);
                if (n_acc < 2) acc_addr[n_acc] = mem_addr;
                n_acc++;
                wcnt = 0;
            end else begin
                hold_addr = mem_addr;
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0]  mode;
        logic [15:0] field;
        logic [15:0] xr;
        logic [15:0] sp;
        logic [2:0]  lat;
        logic [1:0]  acc;
        logic        ill;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'h0041, 16'h0000, 16'h0000, 3'd0, 2'd0, 1'b0},
        '{3'd0, 16'hFFFF, 16'h1111, 16'h2222, 3'd0, 2'd0, 1'b0},
        '{3'd1, 16'h0123, 16'h0000, 16'h0000, 3'd0, 2'd1, 1'b0},
        '{3'd1, 16'hBEEF, 16'h0000, 16'h0000, 3'd3, 2'd1, 1'b0},
        '{3'd2, 16'h0040, 16'h0000, 16'h0000, 3'd1, 2'd2, 1'b0},
        '{3'd2, 16'hFFFF, 16'h0000, 16'h0000, 3'd0, 2'd2, 1'b0},
        '{3'd3, 16'h0010, 16'h1000, 16'h0000, 3'd2, 2'd1, 1'b0},
        '{3'd3, 16'h0020, 16'hFFF0, 16'h0000, 3'd0, 2'd1, 1'b0},
        '{3'd4, 16'h0003, 16'h0000, 16'h0200, 3'd1, 2'd1, 1'b0},
        '{3'd4, 16'hFFFF, 16'h0000, 16'h0001, 3'd2, 2'd1, 1'b0},
        '{3'd5, 16'h1234, 16'h0000, 16'h0000, 3'd0, 2'd0, 1'b1},
        '{3'd7, 16'hFFFF, 16'h0000, 16'h0000, 3'd0, 2'd0, 1'b1}
    };

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [15:0] first_of(input vec_t v);
        case (v.mode)
            3'd3: return v.xr + v.field;
            3'd4: return v.sp + v.field;
            default: return v.field;
        endcase
    endfunction

    function automatic logic [15:0] expect_of(input vec_t v);
        case (v.mode)
            3'd0: return v.field;
            3'd1: return memf(v.field);
            3'd2: return memf(memf(v.field));
            3'd3: return memf(v.xr + v.field);
            3'd4: return memf(v.sp + v.field);
            default: return 16'h0000;
        endcase
    endfunction

    logic [15:0] got_res;
    logic        got_ill;

    // Drives one request, waits for done, leaves state for checks.
    task automatic run_op(input vec_t v);
        int t;
        @(negedge clk);
        n_acc = 0;
        cur_lat = int'(v.lat);
        mode = v.mode; field = v.field; xreg = v.xr; sreg = v.sp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 100) begin
            @(negedge clk);
            t++;
        end
        got_res = result;
        got_ill = illegal;
        chk(done, "R8", "done seen", {15'd0, done}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !mem_req, "R10", "ctrl after reset", {13'd0, busy, done, mem_req}, 16'd0);
        chk(mem_addr == 16'h0 && result == 16'h0, "R10", "regs after reset", mem_addr | result, 16'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i]);
            chk(got_res == expect_of(VECS[i]), tag_of(VECS[i].mode), "result", got_res, expect_of(VECS[i]));
            chk(got_ill == VECS[i].ill, "R6", "illegal flag", {15'd0, got_ill}, {15'd0, VECS[i].ill});
            chk(n_acc == int'(VECS[i].acc), tag_of(VECS[i].mode), "access count", 16'(n_acc), {14'd0, VECS[i].acc});
            if (VECS[i].acc != 2'd0)
                chk(acc_addr[0] == first_of(VECS[i]), "R7", "first address", acc_addr[0], first_of(VECS[i]));
            if (VECS[i].acc == 2'd2)
                chk(acc_addr[1] == memf(VECS[i].field), "R3", "pointer address", acc_addr[1], memf(VECS[i].field));
            @(negedge clk);
            chk(!done, "R8", "done one cycle", {15'd0, done}, 16'd0);
        end

        // R8: result held while idle with inputs moving
        begin
            vec_t v;
            logic [15:0] keep;
            v = '{3'd1, 16'h0777, 16'h0, 16'h0, 3'd1, 2'd1, 1'b0};
            run_op(v);
            keep = result;
            mode = 3'd0; field = 16'hAAAA;
            repeat (5) @(negedge clk);
            chk(result == keep && !illegal, "R8", "result held", result, keep);
        end

        // R9 / R11: start and register changes while busy are ignored
        begin
            vec_t v;
            v = '{3'd3, 16'h0100, 16'h3000, 16'h0, 3'd5, 2'd1, 1'b0};
            @(negedge clk);
            n_acc = 0; cur_lat = 5;
            mode = v.mode; field = v.field; xreg = v.xr; sreg = v.sp;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            mode = 3'd0; field = 16'h1234; xreg = 16'h9999; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int t = 0; t < 50 && !done; t++) @(negedge clk);
            chk(result == memf(16'h3100), "R11", "sampled inputs", result, memf(16'h3100));
            chk(n_acc == 1, "R9", "busy start ignored", 16'(n_acc), 16'd1);
            @(negedge clk);
            chk(!busy, "R9", "no second op", {15'd0, busy}, 16'd0);
        end

        // R10: reset in the middle of a wait
        begin
            @(negedge clk);
            n_acc = 0; cur_lat = 6;
            mode = 3'd2; field = 16'h0050; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            chk(mem_req, "R7", "request pending", {15'd0, mem_req}, 16'd1);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            chk(!busy && !mem_req && mem_addr == 16'h0, "R10", "mid-op reset", mem_addr, 16'h0);
            chk(result == 16'h0, "R10", "result cleared", result, 16'h0);
        end

        chk(hold_errs == 0, "R7", "address stable while waiting", 16'(hold_errs), 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule